// File: doc/BRIEF.md
# Peer Permission Negotiator for Package Deep Idle

Before the local package may drop into its deep idle state, where uncore power-saving actions are taken, every other node in the system must agree. This block asks each present peer for permission to reach the requested state. It gathers the peers' replies, each of which names the deepest state that peer will allow. It then reports the granted state: the shallowest of the local wish and all peer limits. The same block answers permission requests that arrive from peers. Each answer is a completion that carries the local node's current resolved state.

A negotiation starts with a one-cycle `neg_start` pulse. `peer_mask` selects which of up to `NODES` peers take part. While replies are outstanding, a `sys_changed` pulse marks the replies gathered so far as possibly stale. The block throws them away and queries every peer again. Only one message leaves per cycle, and replies to peers always go out ahead of the block's own requests.

Top module: `pstate_negotiator`

## Requirements
- R1: After reset `busy`, `grant_vld` and `out_vld` are 0.
- R2: After `neg_start`, the block sends one request (`out_cmp`=0) per cycle to each node set in `peer_mask`, in ascending node order. Each request carries `out_state` equal to the `want_state` latched at start. `busy` is 1 from the cycle after the start.
- R3: One cycle after the last awaited completion is accepted, `grant_vld` becomes 1 and `busy` becomes 0. `grant_state` then equals the minimum of the wanted state and the permitted states in the peers' completions (`in_cmp`=1).
- R4: While any present peer has not yet answered, `busy` stays 1 and `grant_vld` stays 0.
- R5: Some completions are ignored and change neither the grant nor its timing: those from a node outside `peer_mask`, and those from a peer that has already answered or has not yet been sent its request.
- R6: A `sys_changed` pulse while busy discards all gathered replies and resends requests to every present peer, in ascending order. The grant is then based only on completions that arrive after the retry.
- R7: An inbound request (`in_cmp`=0) from a present peer is answered with a completion (`out_cmp`=1) to that node, carrying `local_state`. The completion goes out in the cycle after acceptance when nothing else waits. Pending completions leave in ascending node order and take priority over outgoing requests.
- R8: An inbound request from a node outside `peer_mask` is never answered.
- R9: With an empty `peer_mask`, the grant arrives two cycles after the start pulse and equals `want_state`.
- R10: `sys_changed` while idle has no effect: no message leaves, and the grant holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| peer_mask | input | NODES | Peers taking part |
| want_state | input | ST_W | Desired local deep state |
| neg_start | input | 1 | Start a negotiation |
| local_state | input | ST_W | Current resolved local state, sent in replies |
| sys_changed | input | 1 | System state changed; replies may be stale |
| in_vld | input | 1 | Inbound message valid |
| in_cmp | input | 1 | Inbound kind: 1 completion, 0 request |
| in_node | input | NID_W | Sending node |
| in_state | input | ST_W | State in the inbound message |
| out_vld | output | 1 | Outbound message valid |
| out_cmp | output | 1 | Outbound kind: 1 completion, 0 request |
| out_node | output | NID_W | Destination node |
| out_state | output | ST_W | State in the outbound message |
| busy | output | 1 | Negotiation in progress |
| grant_vld | output | 1 | Grant result valid |
| grant_state | output | ST_W | Granted deep state |

## Verification
The bench goes after three kinds of completion. The first is a stale completion sent with state 0 just before a retry. A design that keeps old replies would grant too shallow a state. The second is a duplicate completion from a peer that has already answered. The third is a completion from an absent node. Either one, if counted, would lower the grant or end the negotiation early. The bench also interleaves inbound peer requests with outgoing requests, so that a wrong priority or a lost reply shows up as a wrong message order. Empty masks, and retries that follow a partial set of replies, check that the grant is neither issued early nor withheld.

// File: rtl/pstate_negotiator.sv
module pstate_negotiator #(
  parameter int NODES = 8,
  parameter int ST_W  = 3,
  localparam int NID_W = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NODES-1:0] peer_mask,
  input  logic [ST_W-1:0]  want_state,
  input  logic             neg_start,
  input  logic [ST_W-1:0]  local_state,
  input  logic             sys_changed,
  input  logic             in_vld,
  input  logic             in_cmp,
  input  logic [NID_W-1:0] in_node,
  input  logic [ST_W-1:0]  in_state,
  output logic             out_vld,
  output logic             out_cmp,
  output logic [NID_W-1:0] out_node,
  output logic [ST_W-1:0]  out_state,
  output logic             busy,
  output logic             grant_vld,
  output logic [ST_W-1:0]  grant_state
);

  logic [ST_W-1:0]  want_q, perm_min;
  logic [NODES-1:0] req_todo, waiting, reply_pend;
  logic [NODES-1:0] in_hot, cmp_take, req_take, sel_vec, sent;
  logic [NID_W-1:0] pick;

  assign in_hot   = in_vld ? ((NODES'(1) << in_node) & peer_mask) : '0;
  assign cmp_take = in_cmp ? (in_hot & waiting & ~req_todo) : '0;
  assign req_take = in_cmp ? '0 : in_hot;
  assign sel_vec  = (|reply_pend) ? reply_pend : req_todo;

  always_comb begin
    pick = '0;
    for (int i = NODES - 1; i >= 0; i--)
      if (sel_vec[i]) pick = NID_W'(i);
  end

  assign out_vld   = |sel_vec;
  assign out_cmp   = |reply_pend;
  assign out_node  = pick;
  assign out_state = out_cmp ? local_state : want_q;
  assign sent      = out_vld ? (NODES'(1) << pick) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      want_q      <= '0;
      perm_min    <= '0;
      req_todo    <= '0;
      waiting     <= '0;
      reply_pend  <= '0;
      busy        <= 1'b0;
      grant_vld   <= 1'b0;
      grant_state <= '0;
    end else begin
      reply_pend <= (reply_pend & ~(out_cmp ? sent : '0)) | req_take;
      if (neg_start) begin
        want_q    <= want_state;
        perm_min  <= want_state;
        req_todo  <= peer_mask;
        waiting   <= peer_mask;
        busy      <= 1'b1;
        grant_vld <= 1'b0;
      end else if (busy && sys_changed) begin
        perm_min <= want_q;
        req_todo <= peer_mask;
        waiting  <= peer_mask;
      end else if (busy) begin
        req_todo <= req_todo & ~(out_cmp ? '0 : sent);
        waiting  <= waiting & ~cmp_take;
        if ((|cmp_take) && in_state < perm_min) perm_min <= in_state;
        if (waiting == '0 && req_todo == '0) begin
          busy        <= 1'b0;
          grant_vld   <= 1'b1;
          grant_state <= perm_min;
        end
      end
    end
  end

  p_idle_after_reset_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> !busy && !grant_vld && !out_vld);

  p_req_to_present_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld && !out_cmp |-> peer_mask[out_node] && out_state == want_q);

  p_grant_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_vld) |-> grant_state <= want_q && !busy);

  p_busy_excludes_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !grant_vld);

  p_retry_keeps_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && sys_changed && !neg_start |=> busy && !grant_vld);

  p_reply_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld && !in_cmp && peer_mask[in_node] |=> out_vld && out_cmp);

endmodule

// File: tb/pstate_negotiator_test.sv
module pstate_negotiator_test;
  logic clk = 0, rst_n = 0;
  logic [7:0] peer_mask = 0;
  logic [2:0] want_state = 0, local_state = 0, in_state = 0;
  logic neg_start = 0, sys_changed = 0, in_vld = 0, in_cmp = 0;
  logic [2:0] in_node = 0;
  logic out_vld, out_cmp, busy, grant_vld;
  logic [2:0] out_node, out_state, grant_state;
  logic [2:0] perm [8];
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pstate_negotiator uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic send(input bit c, input int n, input logic [2:0] s);
    in_vld = 1; in_cmp = c; in_node = 3'(n); in_state = s;
    @(negedge clk);
    in_vld = 0;
  endtask

  task automatic collect(input logic [7:0] m, input logic [2:0] w);
    for (int i = 0; i < 8; i++)
      if (m[i]) begin
        chk(out_vld && !out_cmp && out_node == 3'(i) && out_state == w,
            "R2 request order", {out_vld, out_cmp, out_node}, {2'b10, 3'(i)});
        @(negedge clk);
      end
  endtask

  task automatic run_neg(input logic [7:0] m, input logic [2:0] w, input bit stl);
    logic [2:0] exp;
    int first, cnt;
    peer_mask = m; want_state = w;
    for (int i = 0; i < 8; i++) perm[i] = 3'($urandom_range(0, 7));
    neg_start = 1; @(negedge clk); neg_start = 0;
    chk(busy === 1'b1, "R2 busy", busy, 1);
    collect(m, w);
    if (stl && m != 0) begin
      first = 0;
      for (int i = 7; i >= 0; i--) if (m[i]) first = i;
      send(1, first, 3'd0);
      sys_changed = 1; @(negedge clk); sys_changed = 0;
      chk(busy && !grant_vld, "R6 retry busy", grant_vld, 0);
      collect(m, w);
    end
    if (m != 8'hFF) begin
      for (int j = 0; j < 8; j++)
        if (!m[j]) begin send(1, j, 3'd0); break; end
    end
    exp = w;
    for (int i = 0; i < 8; i++) if (m[i] && perm[i] < exp) exp = perm[i];
    cnt = 0;
    for (int i = 7; i >= 0; i--)
      if (m[i]) begin
        chk(busy === 1'b1 && grant_vld === 1'b0, "R4 no early grant", grant_vld, 0);
        send(1, i, perm[i]);
        cnt++;
        if (cnt == 1 && m != (8'h1 << i)) send(1, i, 3'd0);
      end
    @(negedge clk);
    chk(grant_vld === 1'b1 && busy === 1'b0, "R3 grant valid", grant_vld, 1);
    chk(grant_state == exp, "R3/R5/R6 grant value", grant_state, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_up();
  end

  initial begin
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    chk(!busy && !grant_vld && !out_vld, "R1 reset state", {busy, grant_vld, out_vld}, 0);
    rst_n = 1; @(negedge clk);

    // R9 exact timing with empty mask
    peer_mask = 0; want_state = 3'd5;
    neg_start = 1; @(negedge clk); neg_start = 0;
    chk(busy && !grant_vld, "R9 first cycle", grant_vld, 0);
    @(negedge clk);
    chk(grant_vld && grant_state == 3'd5, "R9 grant", grant_state, 5);

    // R10 idle stale
    sys_changed = 1; @(negedge clk); sys_changed = 0;
    chk(!out_vld && !busy && grant_vld && grant_state == 3'd5, "R10 idle stale", out_vld, 0);

    // R7 reply order and content
    peer_mask = 8'hFF; local_state = 3'd4;
    in_vld = 1; in_cmp = 0; in_node = 3'd5; @(negedge clk);
    chk(out_vld && out_cmp && out_node == 3'd5 && out_state == 3'd4, "R7 reply 5", out_node, 5);
    in_node = 3'd2; @(negedge clk);
    chk(out_vld && out_cmp && out_node == 3'd2, "R7 reply 2", out_node, 2);
    in_node = 3'd7; @(negedge clk); in_vld = 0;
    chk(out_vld && out_cmp && out_node == 3'd7, "R7 reply 7", out_node, 7);
    @(negedge clk);
    chk(!out_vld, "R7 drained", out_vld, 0);

    // R8 absent requester
    peer_mask = 8'hBF;
    send(0, 6, 3'd0);
    chk(!out_vld, "R8 absent request", out_vld, 0);
    @(negedge clk);
    chk(!out_vld, "R8 still quiet", out_vld, 0);

    // R7 priority over outgoing requests
    peer_mask = 8'h0E; want_state = 3'd6; local_state = 3'd1;
    neg_start = 1; @(negedge clk); neg_start = 0;
    chk(out_vld && !out_cmp && out_node == 3'd1, "R2 first request", out_node, 1);
    send(0, 3, 3'd0);
    chk(out_vld && out_cmp && out_node == 3'd3 && out_state == 3'd1, "R7 priority", out_cmp, 1);
    @(negedge clk);
    chk(out_vld && !out_cmp && out_node == 3'd2, "R2 resumes", out_node, 2);
    @(negedge clk);
    chk(out_vld && !out_cmp && out_node == 3'd3, "R2 last", out_node, 3);
    @(negedge clk);
    send(1, 1, 3'd3); send(1, 2, 3'd5);
    chk(busy && !grant_vld, "R4 one missing", grant_vld, 0);
    send(1, 3, 3'd4);
    chk(busy && !grant_vld, "R3 one cycle later", busy, 1);
    @(negedge clk);
    chk(grant_vld && !busy && grant_state == 3'd3, "R3 directed min", grant_state, 3);

    // random mix
    for (int k = 0; k < 40; k++) begin
      local_state = 3'($urandom_range(0, 7));
      run_neg((k % 10 == 9) ? 8'h00 : 8'($urandom_range(0, 255)),
              3'($urandom_range(0, 7)), bit'($urandom_range(0, 1)));
    end
    run_neg(8'hFF, 3'd7, 1'b1);

    finish_up();
  end
endmodule